// File: doc/BRIEF.md
# Hour to dual seven-segment decoder

This block turns a binary hour count in the range 1 to 12 into two seven-segment patterns, one for the tens position and one for the units position. Because it splits the count itself, the hour counter in front of it can be a plain binary 1-to-12 counter. Two separate BCD hour counters are not needed. A second, independent channel decodes one BCD digit into a segment pattern. It is meant for minute digits. A minute tens value that is only three bits wide is fed with its top bit tied to 0.

Every segment vector is active high. Bit 0 drives segment A, bit 1 drives B, and so on up to bit 6, which drives G. Codes that fall outside the valid range blank their display, meaning every segment is off.

The parameter `OUT_REG` selects where the results leave the block. At 1, the default, the three segment vectors pass through a register with an asynchronous active-low reset. At 0 they come straight from the decode logic.

Top module: `hour_seg_decoder`

## Requirements
- R1: For hour values 1 to 9, the tens output shows the digit 0 (7'h3F) and the units output shows the hour value.
- R2: For hour values 10, 11 and 12, the tens output shows the digit 1 (7'h06) and the units output shows 0, 1 or 2 respectively.
- R3: Hour value 0 and hour values 13 to 15 blank both hour outputs (7'h00).
- R4: BCD digits 0 to 9 give these patterns, with bit 0 = A through bit 6 = G: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. The same patterns are used for hour digits.
- R5: BCD digit inputs 10 to 15 blank the digit output (7'h00).
- R6: With OUT_REG=1, each output takes the decode of the inputs sampled at a rising clock edge. It holds that value until the next rising edge.
- R7: With OUT_REG=1, while rst_n is low, all three outputs are blank. The reset acts without waiting for a clock edge.
- R8: With OUT_REG=0, all three outputs follow the inputs in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| hour_bin | input | 4 | Binary hour value, valid range 1 to 12 |
| digit_bcd | input | 4 | BCD digit for the extra channel, valid range 0 to 9 |
| seg_hour_tens | output | 7 | Segments A..G (bit 0..6) for the hour tens display |
| seg_hour_units | output | 7 | Segments A..G (bit 0..6) for the hour units display |
| seg_digit | output | 7 | Segments A..G (bit 0..6) for the BCD digit display |

## Verification
In the registered variant, each result is due at the first rising edge after the stimulus. The bench therefore changes inputs on a falling edge and reads that variant's outputs at the next falling edge. It also reads them 1 ns after the change, to confirm they still hold the previous result. The combinational variant runs beside it on the same inputs. Its outputs are due in the same cycle and are read 1 ns after each change. The reset checks are taken between clock edges, including one taken while reset is asserted in the middle of a clock period.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    localparam int SEG_W = 7;
    typedef logic [SEG_W-1:0] seg_t;
    localparam seg_t SEG_OFF = '0;

    typedef struct packed {
        seg_t tens;
        seg_t units;
        seg_t digit;
    } seg_bank_t;
endpackage

// File: rtl/hsd_hour_split.sv
module hsd_hour_split #(
    parameter int HOUR_W   = 4,
    parameter int DIGIT_W  = 4,
    parameter int HOUR_MAX = 12
) (
    input  logic [HOUR_W-1:0]  hour,
    output logic [DIGIT_W-1:0] tens,
    output logic [DIGIT_W-1:0] units,
    output logic               in_range
);
    localparam int RADIX = 10;

    always_comb begin
        int h;
        h        = int'(hour);
        in_range = (h >= 1) && (h <= HOUR_MAX);
        tens     = DIGIT_W'(h / RADIX);
        units    = DIGIT_W'(h % RADIX);
    end
endmodule

// File: rtl/hsd_digit_dec.sv
module hsd_digit_dec
    import hsd_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] digit,
    input  logic               enable,
    output seg_t               seg
);
    // bit 0 = A ... bit 6 = G, active high
    always_comb begin
        int d;
        d = int'(digit);
        case (d)
            0:       seg = 7'h3F;
            1:       seg = 7'h06;
            2:       seg = 7'h5B;
            3:       seg = 7'h4F;
            4:       seg = 7'h66;
            5:       seg = 7'h6D;
            6:       seg = 7'h7D;
            7:       seg = 7'h07;
            8:       seg = 7'h7F;
            9:       seg = 7'h6F;
            default: seg = SEG_OFF;
        endcase
        if (!enable) begin
            seg = SEG_OFF;
        end
    end
endmodule

// File: rtl/hour_seg_decoder.sv
module hour_seg_decoder
    import hsd_pkg::*;
#(
    parameter int HOUR_W   = 4,
    parameter int DIGIT_W  = 4,
    parameter int HOUR_MAX = 12,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOUR_W-1:0]  hour_bin,
    input  logic [DIGIT_W-1:0] digit_bcd,
    output logic [SEG_W-1:0]   seg_hour_tens,
    output logic [SEG_W-1:0]   seg_hour_units,
    output logic [SEG_W-1:0]   seg_digit
);
    localparam int N_DEC = 3;
    localparam int IDX_TENS  = 0;
    localparam int IDX_UNITS = 1;
    localparam int IDX_DIGIT = 2;

    logic [DIGIT_W-1:0] tens_dig;
    logic [DIGIT_W-1:0] units_dig;
    logic               hour_ok;

    hsd_hour_split #(
        .HOUR_W   (HOUR_W),
        .DIGIT_W  (DIGIT_W),
        .HOUR_MAX (HOUR_MAX)
    ) u_split (
        .hour     (hour_bin),
        .tens     (tens_dig),
        .units    (units_dig),
        .in_range (hour_ok)
    );

    logic [N_DEC-1:0][DIGIT_W-1:0] dec_in;
    logic [N_DEC-1:0]              dec_en;
    logic [N_DEC-1:0][SEG_W-1:0]   dec_seg;

    always_comb begin
        dec_in[IDX_TENS]  = tens_dig;
        dec_in[IDX_UNITS] = units_dig;
        dec_in[IDX_DIGIT] = digit_bcd;
        dec_en[IDX_TENS]  = hour_ok;
        dec_en[IDX_UNITS] = hour_ok;
        dec_en[IDX_DIGIT] = 1'b1;
    end

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        hsd_digit_dec #(
            .DIGIT_W (DIGIT_W)
        ) u_dec (
            .digit  (dec_in[g]),
            .enable (dec_en[g]),
            .seg    (dec_seg[g])
        );
    end

    seg_bank_t bank_d;
    seg_bank_t bank_q;
    seg_bank_t bank_out;

    always_comb begin
        bank_d.tens  = dec_seg[IDX_TENS];
        bank_d.units = dec_seg[IDX_UNITS];
        bank_d.digit = dec_seg[IDX_DIGIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    if (OUT_REG) begin : g_reg_out
        assign bank_out = bank_q;
    end else begin : g_comb_out
        assign bank_out = bank_d;
    end

    assign seg_hour_tens  = bank_out.tens;
    assign seg_hour_units = bank_out.units;
    assign seg_digit      = bank_out.digit;
endmodule

// File: rtl/hour_seg_decoder_chk.sv
module hour_seg_decoder_chk #(
    parameter int HOUR_W   = 4,
    parameter int DIGIT_W  = 4,
    parameter int HOUR_MAX = 12,
    parameter bit OUT_REG  = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HOUR_W-1:0]  hour_bin,
    input logic [DIGIT_W-1:0] digit_bcd,
    input logic [6:0]         seg_hour_tens,
    input logic [6:0]         seg_hour_units,
    input logic [6:0]         seg_digit
);
    logic hour_bad;
    logic digit_bad;
    assign hour_bad  = (int'(hour_bin) == 0) || (int'(hour_bin) > HOUR_MAX);
    assign digit_bad = int'(digit_bcd) > 9;

    AST_TENS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        seg_hour_tens == 7'h00 || seg_hour_tens == 7'h3F || seg_hour_tens == 7'h06); // R1

    AST_BLANK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_hour_tens == 7'h00) == (seg_hour_units == 7'h00)); // R3

    AST_TENS_ONE_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
        seg_hour_tens == 7'h06 |->
        (seg_hour_units == 7'h3F || seg_hour_units == 7'h06 || seg_hour_units == 7'h5B)); // R2

    if (OUT_REG) begin : g_reg
        AST_HOUR_OOR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
            hour_bad |=> (seg_hour_tens == 7'h00 && seg_hour_units == 7'h00)); // R3
        AST_DIGIT_OOR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
            digit_bad |=> seg_digit == 7'h00); // R5
        AST_HOUR_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            !hour_bad |=> seg_hour_units != 7'h00); // R6
    end else begin : g_comb
        AST_HOUR_OOR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
            hour_bad |-> (seg_hour_tens == 7'h00 && seg_hour_units == 7'h00)); // R3
        AST_DIGIT_OOR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
            digit_bad |-> seg_digit == 7'h00); // R5
        AST_HOUR_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            !hour_bad |-> seg_hour_units != 7'h00); // R8
    end
endmodule

bind hour_seg_decoder hour_seg_decoder_chk #(
    .HOUR_W   (HOUR_W),
    .DIGIT_W  (DIGIT_W),
    .HOUR_MAX (HOUR_MAX),
    .OUT_REG  (OUT_REG)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hour_bin       (hour_bin),
    .digit_bcd      (digit_bcd),
    .seg_hour_tens  (seg_hour_tens),
    .seg_hour_units (seg_hour_units),
    .seg_digit      (seg_digit)
);

// File: tb/hour_seg_decoder_bench.sv
`timescale 1ns/1ps
module hour_seg_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hour = 4'd5;
    logic [3:0] digit = 4'd5;
    logic [6:0] r_tens, r_units, r_digit;
    logic [6:0] c_tens, c_units, c_digit;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hour_seg_decoder #(.OUT_REG(1'b1)) u_hour_seg_decoder (
        .clk(clk), .rst_n(rst_n), .hour_bin(hour), .digit_bcd(digit),
        .seg_hour_tens(r_tens), .seg_hour_units(r_units), .seg_digit(r_digit)
    );

    hour_seg_decoder #(.OUT_REG(1'b0)) u_hour_seg_decoder_comb (
        .clk(clk), .rst_n(rst_n), .hour_bin(hour), .digit_bcd(digit),
        .seg_hour_tens(c_tens), .seg_hour_units(c_units), .seg_digit(c_digit)
    );

    typedef struct packed {
        logic [3:0] hr;
        logic [3:0] dg;
        logic [6:0] t;
        logic [6:0] u;
        logic [6:0] d;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{4'd0,  4'd0,  7'h00, 7'h00, 7'h3F},
        '{4'd1,  4'd1,  7'h3F, 7'h06, 7'h06},
        '{4'd2,  4'd2,  7'h3F, 7'h5B, 7'h5B},
        '{4'd3,  4'd3,  7'h3F, 7'h4F, 7'h4F},
        '{4'd4,  4'd4,  7'h3F, 7'h66, 7'h66},
        '{4'd5,  4'd5,  7'h3F, 7'h6D, 7'h6D},
        '{4'd6,  4'd6,  7'h3F, 7'h7D, 7'h7D},
        '{4'd7,  4'd7,  7'h3F, 7'h07, 7'h07},
        '{4'd8,  4'd8,  7'h3F, 7'h7F, 7'h7F},
        '{4'd9,  4'd9,  7'h3F, 7'h6F, 7'h6F},
        '{4'd10, 4'd10, 7'h06, 7'h3F, 7'h00},
        '{4'd11, 4'd11, 7'h06, 7'h06, 7'h00},
        '{4'd12, 4'd12, 7'h06, 7'h5B, 7'h00},
        '{4'd13, 4'd13, 7'h00, 7'h00, 7'h00},
        '{4'd14, 4'd14, 7'h00, 7'h00, 7'h00},
        '{4'd15, 4'd15, 7'h00, 7'h00, 7'h00}
    };

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string hour_req(input logic [3:0] h);
        if (h >= 4'd1 && h <= 4'd9) return "R1";
        if (h >= 4'd10 && h <= 4'd12) return "R2";
        return "R3";
    endfunction

    function automatic string digit_req(input logic [3:0] d);
        return (d <= 4'd9) ? "R4" : "R5";
    endfunction

    initial begin
        // R7: reset holds registered outputs blank; R8: comb path live meanwhile
        @(negedge clk);
        @(negedge clk);
        chk("R7 tens in reset", r_tens, 7'h00);
        chk("R7 units in reset", r_units, 7'h00);
        chk("R7 digit in reset", r_digit, 7'h00);
        chk("R8 comb units during reset", c_units, 7'h6D);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 first edge after reset", r_units, 7'h6D);

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            hour  = VECS[i].hr;
            digit = VECS[i].dg;
            #1;
            chk({"R8 comb tens ", hour_req(hour)}, c_tens, VECS[i].t);
            chk({"R8 comb units ", hour_req(hour)}, c_units, VECS[i].u);
            chk({"R8 comb digit ", digit_req(digit)}, c_digit, VECS[i].d);
            if (i > 0) begin
                chk("R6 hold before edge", r_units, VECS[i-1].u);
                chk("R6 hold digit before edge", r_digit, VECS[i-1].d);
            end
            @(negedge clk);
            chk({"tens ", hour_req(hour)}, r_tens, VECS[i].t);
            chk({"units ", hour_req(hour)}, r_units, VECS[i].u);
            chk({"digit ", digit_req(digit)}, r_digit, VECS[i].d);
        end

        // R2 then mid-period asynchronous reset, R7
        @(negedge clk);
        hour  = 4'd12;
        digit = 4'd9;
        @(negedge clk);
        chk("R2 twelve tens", r_tens, 7'h06);
        chk("R2 twelve units", r_units, 7'h5B);
        #2 rst_n = 1'b0;
        #1;
        chk("R7 async tens", r_tens, 7'h00);
        chk("R7 async units", r_units, 7'h00);
        chk("R7 async digit", r_digit, 7'h00);
        chk("R8 comb unaffected by reset", c_digit, 7'h6F);
        @(negedge clk);
        rst_n = 1'b1;
        hour  = 4'd10;
        digit = 4'd0;
        @(negedge clk);
        chk("R2 ten tens", r_tens, 7'h06);
        chk("R2 ten units", r_units, 7'h3F);
        chk("R4 zero digit", r_digit, 7'h3F);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule